// File: doc/BRIEF.md
# Control-Encoded Integer ALU

This block is the combinational integer arithmetic unit of a small load/store processor core. It takes two operands and a 3-bit operation code. It returns a result word and three flags: zero, signed overflow and carry-out. The operation code is built from two parts. The top bit both inverts the second operand and supplies the carry into the lowest bit, so a single adder serves addition, subtraction and signed comparison. The two low bits pick which per-bit source reaches the result: AND, OR, sum, or the comparison input.

Signed less-than is computed from the difference. The sign of the difference is XORed with the subtract overflow, and the outcome is fed into bit 0 only. Every other bit receives 0. Equality is tested by subtracting and reading the zero flag. A parameter chooses how the carry chain is built: a plain bit-by-bit ripple, or lookahead over fixed-size groups. Both forms give identical ports.

Top module: `int_alu_core`

## Requirements
- R1: Code 3'b000 returns the bitwise AND of the operands, and code 3'b001 returns the bitwise OR.
- R2: Code 3'b010 returns the sum of the operands modulo 2^WIDTH.
- R3: Code 3'b110 returns A minus B, formed as A + ~B + 1 modulo 2^WIDTH.
- R4: Code 3'b111 returns 1 in bit 0 when A is less than B as signed numbers, otherwise 0. All higher bits are 0. The answer stays correct when A minus B overflows.
- R5: The zero flag is 1 exactly when every result bit is 0, so equal operands under code 3'b110 raise it.
- R6: For codes 3'b010 and 3'b110, overflow is 1 when the signed result has the wrong sign. That is: two non-negatives sum to a negative, two negatives sum to a non-negative, a non-negative minus a negative is negative, or a negative minus a non-negative is non-negative. For every other code, overflow is 0.
- R7: For codes 3'b010 and 3'b110, carry-out is the carry leaving the top bit of the adder. Under subtraction this is 1 when A >= B unsigned. For every other code, carry-out is 0.
- R8: Codes 3'b011, 3'b100 and 3'b101 return an all-zero result with overflow and carry-out at 0, which leaves the zero flag at 1.
- R9: An add of operands with opposite signs never flags overflow, and a subtract of operands with the same sign never flags overflow.
- R10: The ripple carry chain (ADDER_KIND 0) and the grouped lookahead chain (ADDER_KIND 1) give identical result and flags for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation code: invert/carry-in in bit 2, source select in bits 1:0 |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Selected result word |
| zero | output | 1 | High when the result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry from the top adder bit for add or subtract |

## Verification
The block holds no state, so any wrong internal value shows at the ports in the same evaluation as the stimulus that exposes it. A fault in the carry chain shows up first in the upper result bits and in carry_out, and it reaches slt through the sign of the difference. A wrong carry into the top bit makes overflow disagree with the operand-sign rule. The overflow-crossing corners, such as the most negative value compared against positive values, separate a raw sign-bit compare from the corrected one.

// File: rtl/int_alu_pkg.sv
`timescale 1ns/1ps
package int_alu_pkg;

   typedef enum logic [2:0] {
      OPC_AND  = 3'b000,
      OPC_OR   = 3'b001,
      OPC_ADD  = 3'b010,
      OPC_SUB  = 3'b110,
      OPC_SLT  = 3'b111
   } alu_opc_e;

   typedef enum logic [1:0] {
      SRC_AND  = 2'b00,
      SRC_OR   = 2'b01,
      SRC_SUM  = 2'b10,
      SRC_LESS = 2'b11
   } alu_src_e;

   typedef struct packed {
      logic     negate_b;
      alu_src_e src;
      logic     legal;
      logic     arith;
   } alu_ctrl_t;

   localparam int ADDER_RIPPLE    = 0;
   localparam int ADDER_LOOKAHEAD = 1;

endpackage

// File: rtl/int_alu_decode.sv
`timescale 1ns/1ps
module int_alu_decode
   import int_alu_pkg::*;
(
   input  logic [2:0] op_code,
   output alu_ctrl_t  ctrl
);

   always_comb begin
      ctrl.negate_b = op_code[2];
      ctrl.src      = alu_src_e'(op_code[1:0]);
      ctrl.legal    = 1'b0;
      ctrl.arith    = 1'b0;
      case (op_code)
         OPC_AND, OPC_OR, OPC_SLT: ctrl.legal = 1'b1;
         OPC_ADD, OPC_SUB: begin
            ctrl.legal = 1'b1;
            ctrl.arith = 1'b1;
         end
         default: ctrl.legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/int_alu_adder.sv
`timescale 1ns/1ps
module int_alu_adder #(
   parameter int WIDTH      = 32,
   parameter int ADDER_KIND = 0,
   parameter int GROUP      = 4
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             carry_top_in,
   output logic             cout
);

   localparam int NGROUPS = WIDTH / GROUP;

   logic [WIDTH-1:0] gen_b, prp_b, hlf_b;

   assign gen_b = x & y;
   assign prp_b = x | y;
   assign hlf_b = x ^ y;

   generate
      if (ADDER_KIND == 0) begin : g_ripple
         always_comb begin
            logic c;
            c            = cin;
            sum          = '0;
            carry_top_in = 1'b0;
            for (int i = 0; i < WIDTH; i++) begin
               sum[i] = hlf_b[i] ^ c;
               if (i == WIDTH - 1) carry_top_in = c;
               c = gen_b[i] | (prp_b[i] & c);
            end
            cout = c;
         end
      end else begin : g_lookahead
         always_comb begin
            logic c_grp, c_loc, grp_g, grp_p;
            int   idx;
            c_grp        = cin;
            sum          = '0;
            carry_top_in = 1'b0;
            for (int g = 0; g < NGROUPS; g++) begin
               grp_g = 1'b0;
               grp_p = 1'b1;
               c_loc = c_grp;
               for (int k = 0; k < GROUP; k++) begin
                  idx      = g * GROUP + k;
                  sum[idx] = hlf_b[idx] ^ c_loc;
                  if (idx == WIDTH - 1) carry_top_in = c_loc;
                  c_loc    = gen_b[idx] | (prp_b[idx] & c_loc);
                  grp_g    = gen_b[idx] | (prp_b[idx] & grp_g);
                  grp_p    = grp_p & prp_b[idx];
               end
               c_grp = grp_g | (grp_p & c_grp);
            end
            cout = c_grp;
         end
      end
   endgenerate

   always_comb begin
      if (ADDER_KIND == 0 && !cin && (x & y) == '0)
         assert_ripple_no_carry_R2: assert (!cout);
   end

endmodule

// File: rtl/int_alu_select.sv
`timescale 1ns/1ps
module int_alu_select
   import int_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_ctrl_t        ctrl,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] sum,
   input  logic             less_in,
   output logic [WIDTH-1:0] res
);

   generate
      for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
         logic less_here;
         if (gi == 0) begin : g_lsb
            assign less_here = less_in;
         end else begin : g_upper
            assign less_here = 1'b0;
         end
         assign res[gi] = ctrl.legal & (
              (ctrl.src == SRC_AND)  ? (a[gi] & b[gi]) :
              (ctrl.src == SRC_OR)   ? (a[gi] | b[gi]) :
              (ctrl.src == SRC_SUM)  ? sum[gi]         : less_here);
      end
   endgenerate

endmodule

// File: rtl/int_alu_core.sv
`timescale 1ns/1ps
module int_alu_core
   import int_alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ADDER_KIND = ADDER_RIPPLE,
   parameter int GROUP      = 4
) (
   input  logic [2:0]       op_code,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] result,
   output logic             zero,
   output logic             overflow,
   output logic             carry_out
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("int_alu_core: WIDTH must be at least 2");
      end
      if (ADDER_KIND != ADDER_RIPPLE && ADDER_KIND != ADDER_LOOKAHEAD) begin : g_bad_kind
         $error("int_alu_core: unknown ADDER_KIND");
      end
      if (ADDER_KIND == ADDER_LOOKAHEAD && (GROUP < 1 || WIDTH % GROUP != 0)) begin : g_bad_group
         $error("int_alu_core: GROUP must divide WIDTH");
      end
   endgenerate

   alu_ctrl_t        ctrl;
   logic [WIDTH-1:0] b_eff, sum;
   logic             c_top_in, c_out, add_ovf, less_bit;

   int_alu_decode u_dec (
      .op_code (op_code),
      .ctrl    (ctrl)
   );

   assign b_eff = ctrl.negate_b ? ~opnd_b : opnd_b;

   int_alu_adder #(
      .WIDTH      (WIDTH),
      .ADDER_KIND (ADDER_KIND),
      .GROUP      (GROUP)
   ) u_add (
      .x            (opnd_a),
      .y            (b_eff),
      .cin          (ctrl.negate_b),
      .sum          (sum),
      .carry_top_in (c_top_in),
      .cout         (c_out)
   );

   // signed overflow: carry into the sign bit differs from carry out of it
   assign add_ovf  = c_top_in ^ c_out;
   assign less_bit = sum[MSB] ^ add_ovf;

   int_alu_select #(.WIDTH(WIDTH)) u_sel (
      .ctrl    (ctrl),
      .a       (opnd_a),
      .b       (opnd_b),
      .sum     (sum),
      .less_in (less_bit),
      .res     (result)
   );

   assign zero      = ~|result;
   assign overflow  = ctrl.arith & add_ovf;
   assign carry_out = ctrl.arith & c_out;

   always_comb begin
      if (op_code == OPC_SLT)
         assert_slt_signed_R4: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))});
      if (op_code == OPC_SUB && opnd_a == opnd_b)
         assert_equal_gives_zero_R5: assert (zero);
      if (op_code != OPC_ADD && op_code != OPC_SUB)
         assert_flags_quiet_R6: assert (!overflow && !carry_out);
      if (op_code == 3'b011 || op_code == 3'b100 || op_code == 3'b101)
         assert_unused_clear_R8: assert (result == '0);
      if ((op_code == OPC_ADD && opnd_a[MSB] != opnd_b[MSB]) ||
          (op_code == OPC_SUB && opnd_a[MSB] == opnd_b[MSB]))
         assert_no_overflow_R9: assert (!overflow);
   end

endmodule

// File: tb/int_alu_core_test.sv
`timescale 1ns/1ps
module int_alu_core_test;

   logic        clk = 1'b0;
   logic [2:0]  op;
   logic [31:0] a, b;
   logic [31:0] res_r, res_l;
   logic        z_r, z_l, v_r, v_l, c_r, c_l;
   int          n_chk = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   int_alu_core #(.WIDTH(32), .ADDER_KIND(0)) uut (
      .op_code(op), .opnd_a(a), .opnd_b(b),
      .result(res_r), .zero(z_r), .overflow(v_r), .carry_out(c_r));

   int_alu_core #(.WIDTH(32), .ADDER_KIND(1), .GROUP(4)) uut_cla (
      .op_code(op), .opnd_a(a), .opnd_b(b),
      .result(res_l), .zero(z_l), .overflow(v_l), .carry_out(c_l));

   function automatic logic [31:0] exp_res(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
      case (o)
         3'b000:  return x & y;
         3'b001:  return x | y;
         3'b010:  return x + y;
         3'b110:  return x - y;
         3'b111:  return {31'd0, ($signed(x) < $signed(y))};
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic exp_ovf(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
      logic [31:0] s;
      if (o == 3'b010) begin
         s = x + y;
         return (x[31] == y[31]) && (s[31] != x[31]);
      end
      if (o == 3'b110) begin
         s = x - y;
         return (x[31] != y[31]) && (s[31] != x[31]);
      end
      return 1'b0;
   endfunction

   function automatic logic exp_cy(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
      logic [32:0] w;
      if (o == 3'b010) begin
         w = {1'b0, x} + {1'b0, y};
         return w[32];
      end
      if (o == 3'b110) return x >= y;
      return 1'b0;
   endfunction

   function automatic string res_tag(input logic [2:0] o);
      case (o)
         3'b000, 3'b001: return "R1";
         3'b010:         return "R2";
         3'b110:         return "R3";
         3'b111:         return "R4";
         default:        return "R8";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, got, exp);
      end
   endtask

   task automatic run(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
      logic [31:0] er;
      @(posedge clk);
      op = o; a = x; b = y;
      #2;
      er = exp_res(o, x, y);
      chk(res_tag(o), res_r, er);
      chk("R5 zero", {31'd0, z_r}, {31'd0, (er == 32'd0)});
      chk("R6 overflow", {31'd0, v_r}, {31'd0, exp_ovf(o, x, y)});
      chk("R7 carry", {31'd0, c_r}, {31'd0, exp_cy(o, x, y)});
      if ((o == 3'b010 && x[31] != y[31]) || (o == 3'b110 && x[31] == y[31]))
         chk("R9 no overflow", {31'd0, v_r}, 32'd0);
      chk("R10 result", res_l, res_r);
      chk("R10 flags", {29'd0, z_l, v_l, c_l}, {29'd0, z_r, v_r, c_r});
   endtask

   initial begin
      #1_600_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [2:0] o;
      op = 3'b000; a = '0; b = '0;
      #2;
      chk("R5 idle zero", {31'd0, z_r}, 32'd1);
      chk("R1 idle result", res_r, 32'd0);
      // directed corners
      run(3'b000, 32'hF0F0_1234, 32'h0FF0_FFFF);
      run(3'b001, 32'hF0F0_0000, 32'h0000_00FF);
      run(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
      run(3'b010, 32'h8000_0000, 32'h8000_0000);
      run(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
      run(3'b010, 32'h7FFF_FFFF, 32'h8000_0000);
      run(3'b110, 32'h8000_0000, 32'h0000_0001);
      run(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      run(3'b110, 32'h1234_5678, 32'h1234_5678);
      run(3'b110, 32'h0000_0000, 32'h0000_0001);
      run(3'b111, 32'h8000_0000, 32'h0000_0001);
      run(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
      run(3'b111, 32'hFFFF_FFFF, 32'h0000_0000);
      run(3'b111, 32'h0000_0005, 32'h0000_0005);
      run(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run(3'b100, 32'h7FFF_FFFF, 32'h0000_0001);
      run(3'b101, 32'h8000_0000, 32'h8000_0000);
      // constrained random
      void'($urandom(32'd20231));
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] x, y;
         o = 3'($urandom % 8);
         x = $urandom;
         y = $urandom;
         case ($urandom % 6)
            0: y = x;
            1: x = {x[31], 31'h7FFF_FFFF & ($urandom % 4 == 0 ? 32'h7FFF_FFFF : x[30:0])};
            2: y = 32'h8000_0000;
            default: ;
         endcase
         run(o, x, y);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule